// File: doc/BRIEF.md
# Pausable 56-bit Down-Counting Timer

This block is a high-resolution interval timer. A 56-bit counter counts down toward zero. It advances one step per count tick, and a power-of-two prescaler derives that tick from the system clock. Software drives the timer through a flat word-addressed register port: a write strobe, an address, write data and combinational read data. The registers hold a control word, the interval split into a low and a high word, the live counter value split the same way, and a status word with the pending flag and the interrupt enable.

Clearing the run bit pauses the count and keeps its value. Setting the run bit again resumes from that value. The interval is copied into the counter only when the timer starts from its idle state, or when software writes the reload bit. A pause can therefore be used to change the interval without disturbing the count in progress. When software writes reload and run together, the count restarts from the new interval. In one-shot mode the timer stops itself at expiry. In periodic mode it reloads the interval and keeps counting.

Top module: `pausable_down_timer`

## Requirements
- R1: After reset every readable register reads 0 and `irq` is low.
- R2: Word addresses: 0 control, 1 interval bits 31:0, 2 interval bits 55:32 (held in read-data bits 23:0, with bits 31:24 reading 0), 3 counter bits 31:0, 4 counter bits 55:32, 5 status. The interval words read back what was written.
- R3: The control word has run in bit 0, reload in bit 1, one-shot mode in bit 2 and the prescale code in bits 5:3. A run write issued from idle loads the interval into the counter at that clock edge, with no decrement. The counter then drops by one on each tick, and a borrow ripples across the full 56 bits.
- R4: Prescale code n (0 to 4) gives one tick every 2^n clocks, and codes 5 to 7 behave as code 4. Every load clears the divider, so the first tick after a load comes 2^n edges later.
- R5: In one-shot mode (bit 2 = 1), the tick that takes the counter from 1 to 0 sets the pending flag and clears run. The counter then holds at 0.
- R6: In periodic mode (bit 2 = 0), the same tick writes the interval back into the counter, and run stays set.
- R7: While run is 0 the counter value does not change. Writing run = 1 with reload = 0 to a paused timer resumes from the held value, even if the interval has been rewritten in the meantime.
- R8: A control write that sets run is ignored when it falls on the clock edge right after the write that cleared run. From the second edge after that write, a run write is accepted.
- R9: A control write with reload = 1 loads the interval into the counter at that edge. When run is also 1 in the same write, counting restarts from the new interval. The reload bit reads 1 on the cycle after the write and 0 after that.
- R10: Status bit 0 is the pending flag and is cleared by writing 1 to it. Status bit 1 is the interrupt enable. `irq` is high exactly when both are set.
- R11: An interval of 0 behaves like an interval of 1: expiry comes on the first tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Register write strobe |
| addr | input | 3 | Word address |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for `addr`, combinational |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situation to reach is the re-enable window. It needs a write that clears run, followed on the very next edge by a write that sets run. A deeper case adds a count tick on the same edge as the pausing write. The bench drives register writes back to back, with no idle cycle between them, so both collisions occur with the prescaler at divide-by-one. A behavioural model then follows the counter value, the divider phase and the hold-off through every cycle. The one-shot, periodic and zero-interval expiries are reached by reloading short intervals, so that expiry comes within a few ticks.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
  localparam int ADDR_W = 3;
  localparam int PSC_W  = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL   = 3'd0,
    A_IVL_LO = 3'd1,
    A_IVL_HI = 3'd2,
    A_CNT_LO = 3'd3,
    A_CNT_HI = 3'd4,
    A_STAT   = 3'd5
  } regAddr_e;

  // strobes from control to datapath
  typedef struct packed {
    logic             load;
    logic             run;
    logic             oneShot;
    logic [PSC_W-1:0] psc;
    logic             wrLo;
    logic             wrHi;
  } dpStrobe_t;
endpackage

// File: rtl/tmr_ctrl.sv
`timescale 1ns/1ps
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int HOLD_CYC = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [5:0]        wrBits,
  input  logic              expire,
  output dpStrobe_t         strb,
  output logic              reloadQ,
  output logic              pendQ,
  output logic              ieQ,
  output logic              irq
);
  localparam int HW = (HOLD_CYC > 2) ? $clog2(HOLD_CYC) : 1;

  logic             runQ, armedQ, oneShotQ;
  logic [PSC_W-1:0] pscQ;
  logic [HW-1:0]    holdQ;
  logic             ctrlWr, statWr, enAcc, doLoad;

  assign ctrlWr = wrEn && (addr == A_CTRL);
  assign statWr = wrEn && (addr == A_STAT);
  // a run request is honoured only once the hold-off since the last pause ran out
  assign enAcc  = wrBits[0] && (runQ || holdQ == '0);
  assign doLoad = ctrlWr && (wrBits[1] || (enAcc && !runQ && !armedQ));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runQ     <= 1'b0;
      armedQ   <= 1'b0;
      oneShotQ <= 1'b0;
      pscQ     <= '0;
      holdQ    <= '0;
      reloadQ  <= 1'b0;
      pendQ    <= 1'b0;
      ieQ      <= 1'b0;
    end else begin
      if (ctrlWr) begin
        runQ     <= enAcc;
        oneShotQ <= wrBits[2];
        pscQ     <= wrBits[5:3];
      end else if (expire && oneShotQ) begin
        runQ <= 1'b0;
      end

      reloadQ <= ctrlWr && wrBits[1];

      if (ctrlWr && !wrBits[0] && runQ)
        holdQ <= HW'(HOLD_CYC - 1);
      else if (holdQ != '0)
        holdQ <= holdQ - HW'(1);

      if (doLoad)
        armedQ <= 1'b1;
      else if (expire && oneShotQ)
        armedQ <= 1'b0;

      if (expire)
        pendQ <= 1'b1;
      else if (statWr && wrBits[0])
        pendQ <= 1'b0;
      if (statWr)
        ieQ <= wrBits[1];
    end
  end

  always_comb begin
    strb.load    = doLoad;
    strb.run     = runQ;
    strb.oneShot = oneShotQ;
    strb.psc     = pscQ;
    strb.wrLo    = wrEn && (addr == A_IVL_LO);
    strb.wrHi    = wrEn && (addr == A_IVL_HI);
  end

  assign irq = pendQ && ieQ;
endmodule

// File: rtl/tmr_dp.sv
`timescale 1ns/1ps
module tmr_dp
  import tmr_pkg::*;
#(
  parameter int CNT_W     = 56,
  parameter int DATA_W    = 32,
  parameter int MAX_SHIFT = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic [DATA_W-1:0] wrData,
  output logic [CNT_W-1:0]  cnt,
  output logic [CNT_W-1:0]  ivl,
  output logic              expire
);
  localparam int HI_W  = CNT_W - DATA_W;
  localparam int DIV_W = (MAX_SHIFT > 0) ? MAX_SHIFT : 1;

  logic [CNT_W-1:0] cntQ, ivlQ;
  logic [DIV_W-1:0] divQ, divLim;
  logic [PSC_W-1:0] sh;
  logic             tick;

  always_comb begin
    sh     = (int'(strb.psc) > MAX_SHIFT) ? PSC_W'(MAX_SHIFT) : strb.psc;
    divLim = DIV_W'((32'd1 << sh) - 32'd1);
  end

  assign tick   = strb.run && (divQ >= divLim);
  assign expire = tick && (cntQ <= CNT_W'(1)) && !strb.load;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ivlQ <= '0;
    end else begin
      if (strb.wrLo) ivlQ[DATA_W-1:0]     <= wrData;
      if (strb.wrHi) ivlQ[CNT_W-1:DATA_W] <= wrData[HI_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ <= '0;
      divQ <= '0;
    end else begin
      if (strb.load)
        cntQ <= ivlQ;
      else if (expire)
        cntQ <= strb.oneShot ? '0 : ivlQ;
      else if (tick)
        cntQ <= cntQ - CNT_W'(1);

      if (strb.load || tick)
        divQ <= '0;
      else if (strb.run)
        divQ <= divQ + DIV_W'(1);
    end
  end

  assign cnt = cntQ;
  assign ivl = ivlQ;
endmodule

// File: rtl/pausable_down_timer.sv
`timescale 1ns/1ps
module pausable_down_timer
  import tmr_pkg::*;
#(
  parameter int CNT_W     = 56,
  parameter int DATA_W    = 32,
  parameter int MAX_SHIFT = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              irq
);
  dpStrobe_t        strb;
  logic [CNT_W-1:0] cnt, ivl;
  logic             expire, reloadQ, pendQ, ieQ, runQ;

  tmr_ctrl #(.HOLD_CYC(2)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrBits(wrData[5:0]),
    .expire(expire), .strb(strb), .reloadQ(reloadQ), .pendQ(pendQ),
    .ieQ(ieQ), .irq(irq)
  );

  tmr_dp #(.CNT_W(CNT_W), .DATA_W(DATA_W), .MAX_SHIFT(MAX_SHIFT)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData),
    .cnt(cnt), .ivl(ivl), .expire(expire)
  );

  assign runQ = strb.run;

  always_comb begin
    case (regAddr_e'(addr))
      A_CTRL:   rdData = DATA_W'({strb.psc, strb.oneShot, reloadQ, runQ});
      A_IVL_LO: rdData = ivl[DATA_W-1:0];
      A_IVL_HI: rdData = DATA_W'(ivl[CNT_W-1:DATA_W]);
      A_CNT_LO: rdData = cnt[DATA_W-1:0];
      A_CNT_HI: rdData = DATA_W'(cnt[CNT_W-1:DATA_W]);
      A_STAT:   rdData = DATA_W'({ieQ, pendQ});
      default:  rdData = '0;
    endcase
  end
endmodule

// File: rtl/tmr_chk.sv
`timescale 1ns/1ps
module tmr_chk #(
  parameter int CNT_W = 56
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input logic [2:0]       addr,
  input logic [1:0]       wrLow2,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] ivl,
  input logic             runQ,
  input logic             pendQ
);
  logic ctrlWr, statWr;
  assign ctrlWr = wrEn && (addr == 3'd0);
  assign statWr = wrEn && (addr == 3'd5);

  // R7
  pause_freeze_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!runQ && !ctrlWr) |=> $stable(cnt));

  // R3
  step_down_chk: assert property (@(posedge clk) disable iff (!rstN)
    (runQ && !ctrlWr && cnt > CNT_W'(1)) |=>
      (cnt == $past(cnt) || cnt == $past(cnt) - CNT_W'(1)));

  // R9
  reload_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWr && wrLow2[1]) |=> (cnt == $past(ivl)));

  // R8
  reenable_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWr && !wrLow2[0] && runQ) |=> ((ctrlWr && wrLow2[0]) |=> !runQ));

  // R10
  pend_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statWr && wrLow2[0] && !runQ) |=> !pendQ);
endmodule

bind pausable_down_timer tmr_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrLow2(wrData[1:0]),
  .cnt(cnt), .ivl(ivl), .runQ(runQ), .pendQ(pendQ)
);

// File: tb/tb_pausable_down_timer.sv
`timescale 1ns/1ps
module tb_pausable_down_timer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [31:0] wrData = 32'd0;
  logic [31:0] rdData;
  logic        irq;

  pausable_down_timer dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .irq(irq)
  );

  always #10 clk = ~clk;

  int vecs = 0, bad = 0;
  bit done = 1'b0;

  // behavioural reference state
  longint unsigned mIvl = 0, mCnt = 0;
  int mDiv = 0, mHold = 0, mPsc = 0;
  bit mRun = 0, mArmed = 0, mOne = 0, mRel = 0, mPend = 0, mIe = 0;
  localparam longint unsigned M56 = (64'd1 << 56) - 64'd1;

  always @(posedge clk) begin : refModel
    int dv;
    bit tk, cw, sw, ea, ld, ex;
    longint unsigned nc;
    if (!rstN) begin
      mIvl = 0; mCnt = 0; mDiv = 0; mHold = 0; mPsc = 0;
      mRun = 0; mArmed = 0; mOne = 0; mRel = 0; mPend = 0; mIe = 0;
    end else begin
      dv = 1 << ((mPsc > 4) ? 4 : mPsc);
      tk = mRun && (mDiv >= dv - 1);
      cw = wrEn && addr == 3'd0;
      sw = wrEn && addr == 3'd5;
      ea = wrData[0] && (mRun || mHold == 0);
      ld = cw && (wrData[1] || (ea && !mRun && !mArmed));
      ex = tk && (mCnt <= 1) && !ld;
      if (ld) nc = mIvl;
      else if (ex) nc = mOne ? 0 : mIvl;
      else if (tk) nc = mCnt - 1;
      else nc = mCnt;
      if (ld || tk) mDiv = 0; else if (mRun) mDiv = mDiv + 1;
      if (cw && !wrData[0] && mRun) mHold = 1; else if (mHold > 0) mHold = mHold - 1;
      if (ld) mArmed = 1; else if (ex && mOne) mArmed = 0;
      if (ex) mPend = 1; else if (sw && wrData[0]) mPend = 0;
      if (cw) mRun = ea; else if (ex && mOne) mRun = 0;
      mRel = cw && wrData[1];
      if (cw) begin mOne = wrData[2]; mPsc = int'(wrData[5:3]); end
      if (sw) mIe = wrData[1];
      if (wrEn && addr == 3'd1) mIvl = (mIvl & ~64'hFFFF_FFFF) | longint'(wrData);
      if (wrEn && addr == 3'd2) mIvl = (mIvl & 64'hFFFF_FFFF) | (longint'(wrData[23:0]) << 32);
      mCnt = nc & M56;
    end
  end

  function automatic logic [31:0] expRead(input logic [2:0] a);
    case (a)
      3'd0: expRead = {26'd0, mPsc[2:0], mOne, mRel, mRun};
      3'd1: expRead = mIvl[31:0];
      3'd2: expRead = {8'd0, mIvl[55:32]};
      3'd3: expRead = mCnt[31:0];
      3'd4: expRead = {8'd0, mCnt[55:32]};
      3'd5: expRead = {30'd0, mIe, mPend};
      default: expRead = 32'd0;
    endcase
  endfunction

  function automatic logic [31:0] ctl(input bit en, input bit rel, input bit one, input int psc);
    ctl = {26'd0, psc[2:0], one, rel, en};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one clock with the given inputs, then compare against the model
  task automatic step(input bit we, input logic [2:0] a, input logic [31:0] d);
    wrEn = we; addr = a; wrData = d;
    @(posedge clk);
    @(negedge clk);
    chk($sformatf("R2 model read addr %0d", a), rdData, expRead(a));
    chk("R10 model irq", {31'd0, irq}, {31'd0, mPend && mIe});
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 3'd3, 32'd0);
  endtask

  task automatic peek(input logic [2:0] a, output logic [31:0] v);
    wrEn = 1'b0; addr = a;
    #1;
    v = rdData;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    for (int a = 0; a < 6; a++) begin
      peek(3'(a), v);
      chk($sformatf("R1 reset addr %0d", a), v, 32'd0);
    end
    chk("R1 irq after reset", {31'd0, irq}, 32'd0);

    // R2 interval registers and status
    step(1'b1, 3'd2, 32'hFFFF_FFFF);
    peek(3'd2, v); chk("R2 interval high masked", v, 32'h00FF_FFFF);
    step(1'b1, 3'd1, 32'h1234_5678);
    peek(3'd1, v); chk("R2 interval low", v, 32'h1234_5678);
    step(1'b1, 3'd5, 32'd2);
    peek(3'd5, v); chk("R2 status enable", v, 32'd2);
    step(1'b1, 3'd2, 32'd0);

    // R3 start from idle
    step(1'b1, 3'd1, 32'd100);
    step(1'b1, 3'd0, ctl(1, 0, 0, 0));
    peek(3'd3, v); chk("R3 load on start", v, 32'd100);
    idle(1);
    peek(3'd3, v); chk("R3 first decrement", v, 32'd99);

    // R7 pause and resume
    step(1'b1, 3'd0, ctl(0, 0, 0, 0));
    peek(3'd3, v); chk("R7 paused value", v, 32'd98);
    idle(5);
    peek(3'd3, v); chk("R7 frozen", v, 32'd98);
    step(1'b1, 3'd0, ctl(1, 0, 0, 0));
    peek(3'd3, v); chk("R7 resume no reload", v, 32'd98);
    idle(1);
    peek(3'd3, v); chk("R7 resume counts", v, 32'd97);

    // R8 early re-enable ignored
    step(1'b1, 3'd0, ctl(0, 0, 0, 0));
    step(1'b1, 3'd0, ctl(1, 0, 0, 0));
    peek(3'd0, v); chk("R8 early enable ignored", v & 32'd1, 32'd0);
    idle(3);
    peek(3'd3, v); chk("R8 count held", v, 32'd96);
    step(1'b1, 3'd0, ctl(1, 0, 0, 0));
    peek(3'd0, v); chk("R8 later enable accepted", v & 32'd1, 32'd1);

    // R9 interval change while paused
    step(1'b1, 3'd0, ctl(0, 0, 0, 0));
    idle(2);
    step(1'b1, 3'd1, 32'd50);
    step(1'b1, 3'd0, ctl(1, 0, 0, 0));
    peek(3'd3, v); chk("R9 plain resume keeps count", v, 32'd95);
    step(1'b1, 3'd0, ctl(0, 0, 0, 0));
    idle(2);
    step(1'b1, 3'd0, ctl(1, 1, 0, 0));
    peek(3'd0, v); chk("R9 reload bit visible", v, 32'd3);
    peek(3'd3, v); chk("R9 restart from new interval", v, 32'd50);
    step(1'b0, 3'd0, 32'd0);
    peek(3'd0, v); chk("R9 reload bit self-clears", v, 32'd1);
    peek(3'd3, v); chk("R9 counting after restart", v, 32'd49);

    // R4 prescale /4
    step(1'b1, 3'd0, ctl(0, 0, 0, 0));
    idle(2);
    step(1'b1, 3'd1, 32'd1000);
    step(1'b1, 3'd0, ctl(1, 1, 0, 2));
    idle(3);
    peek(3'd3, v); chk("R4 div4 before tick", v, 32'd1000);
    idle(1);
    peek(3'd3, v); chk("R4 div4 tick", v, 32'd999);

    // R4 reserved code acts as /16
    step(1'b1, 3'd0, ctl(0, 0, 0, 2));
    idle(2);
    step(1'b1, 3'd0, ctl(1, 1, 0, 7));
    idle(15);
    peek(3'd3, v); chk("R4 code7 before tick", v, 32'd1000);
    idle(1);
    peek(3'd3, v); chk("R4 code7 tick", v, 32'd999);

    // R5 one-shot expiry
    step(1'b1, 3'd0, ctl(0, 0, 0, 7));
    idle(2);
    step(1'b1, 3'd1, 32'd3);
    step(1'b1, 3'd0, ctl(1, 1, 1, 0));
    idle(2);
    chk("R10 irq low before expiry", {31'd0, irq}, 32'd0);
    idle(1);
    peek(3'd3, v); chk("R5 counter at zero", v, 32'd0);
    peek(3'd0, v); chk("R5 run cleared", v & 32'd1, 32'd0);
    peek(3'd5, v); chk("R10 pending set", v, 32'd3);
    chk("R10 irq raised", {31'd0, irq}, 32'd1);
    idle(3);
    peek(3'd3, v); chk("R5 holds zero", v, 32'd0);

    // R10 write-one-to-clear
    step(1'b1, 3'd5, 32'd3);
    peek(3'd5, v); chk("R10 pending cleared", v, 32'd2);
    chk("R10 irq dropped", {31'd0, irq}, 32'd0);
    step(1'b1, 3'd5, 32'd0);

    // R6 periodic reload
    step(1'b1, 3'd0, ctl(1, 0, 0, 0));
    idle(3);
    peek(3'd3, v); chk("R6 reloaded at expiry", v, 32'd3);
    peek(3'd0, v); chk("R6 still running", v & 32'd1, 32'd1);
    peek(3'd5, v); chk("R10 pending with irq disabled", v, 32'd1);
    chk("R10 irq gated off", {31'd0, irq}, 32'd0);
    idle(1);
    peek(3'd3, v); chk("R6 keeps counting", v, 32'd2);

    // R11 zero interval
    step(1'b1, 3'd0, ctl(0, 0, 0, 0));
    idle(2);
    step(1'b1, 3'd1, 32'd0);
    step(1'b1, 3'd5, 32'd1);
    step(1'b1, 3'd0, ctl(1, 1, 1, 0));
    idle(1);
    peek(3'd5, v); chk("R11 expiry on first tick", v & 32'd1, 32'd1);
    peek(3'd0, v); chk("R11 stopped", v & 32'd1, 32'd0);

    // R3 borrow across the 56-bit word
    step(1'b1, 3'd2, 32'h00AB_CDEF);
    step(1'b1, 3'd1, 32'd0);
    step(1'b1, 3'd0, ctl(1, 1, 0, 0));
    idle(1);
    peek(3'd3, v); chk("R3 borrow low word", v, 32'hFFFF_FFFF);
    peek(3'd4, v); chk("R3 borrow high word", v, 32'h00AB_CDEE);
    idle(4);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule